// File: doc/BRIEF.md
# Deterministic DAC Sample Request Scheduler

This block decides, once per audio frame, whether the codec asks the controller for the next left/right DAC sample pair. The frames arrive at a fixed 48 kHz. With variable-rate operation off, a pair is requested in every frame. With it on, an exact accumulator spaces the requests so that their average rate equals a programmed rate between 4000 and 48000 Hz, in 1 Hz steps. The same rate applies to both channels.

The same schedule also filters incoming samples. A left/right pair that arrives in the frame after a requesting frame is passed on once, as an accepted-sample strobe with data. Every other pair is dropped. Because the spacing depends only on the rate and the number of frames since the last restart, software can predict exactly which frames will ask for data.

Top module: `dac_rate_requester`

## Requirements
- R1: After synchronous reset, `req_n` is 2'b00, `smp_valid` is 0, both sample outputs are zero, the stored rate is 48000 and the accumulator is zero.
- R2: While `var_rate_en` is 0, every `frame_tick` produces a request (`req_n` = 2'b00).
- R3: While `var_rate_en` is 1, each `frame_tick` adds the stored rate to an accumulator. If the sum is 48000 or more, the frame requests and 48000 is subtracted from the sum; otherwise the frame does not request. Over N frames after a restart, the number of requests is floor(N*rate/48000).
- R4: A rate of 8000 requests in exactly every sixth frame. A rate of 9600 requests in exactly every fifth frame. A rate of 12000 requests in every fourth frame.
- R5: A rate of 8800 produces gaps of five or six frames between requests: the first request is in frame 6, and there are 11 requests in 60 frames.
- R6: Written rates below 4000 are stored as 4000, and written rates above 48000 are stored as 48000.
- R7: `req_n` is active low: 0 means send a sample and 1 means do not send. Its two bits, bit 0 for the left slot and bit 1 for the right slot, always carry the same value.
- R8: A pair with `pcm_valid` is accepted only when the most recent frame before the current one requested. Pairs that arrive in any other frame are discarded.
- R9: At most one pair is accepted per frame; a second pair in the same frame is dropped. `smp_left` and `smp_right` hold the last accepted pair until a new one is accepted.
- R10: A `rate_wr` pulse, or any change of `var_rate_en`, clears the accumulator. With 8000 Hz, the next request then falls in the sixth frame that follows.
- R11: `req_n` changes only in the cycle after a `frame_tick`. `smp_valid` and its data appear in the cycle after the accepted `pcm_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle strobe at the start of each frame |
| var_rate_en | input | 1 | 1 = variable rate, 0 = request in every frame |
| rate_wr | input | 1 | Write strobe for `rate_val` |
| rate_val | input | 16 | Requested DAC sample rate in Hz |
| pcm_valid | input | 1 | A received left/right pair is present |
| pcm_left | input | 20 | Received left sample |
| pcm_right | input | 20 | Received right sample |
| req_n | output | 2 | Active-low request bits for the current input frame |
| smp_valid | output | 1 | One-cycle strobe: accepted pair on the sample outputs |
| smp_left | output | 20 | Last accepted left sample |
| smp_right | output | 20 | Last accepted right sample |

## Verification
A wrong accumulator value does not show up at once. It shows as a request one frame early or late, at the latest within twelve frames at the slowest rate. The bench therefore checks the first request, each gap and the total count over whole periods, including the uneven 8800 Hz pattern. A wrong acceptance flag shows at the ports within one frame, as a pair taken or dropped against the previous frame's request. It is exposed by sending a pair in every frame and a duplicate pair within the same frame.

// File: rtl/dac_rate_pkg.sv
package dac_rate_pkg;
  localparam int unsigned FRAME_HZ_DEF = 48000;
  localparam int unsigned MIN_HZ_DEF   = 4000;
  localparam int unsigned RATE_W_DEF   = 16;
  localparam int unsigned SMP_W_DEF    = 20;
  localparam int unsigned REQ_BITS_DEF = 2;
endpackage

// File: rtl/dac_rate_store.sv
module dac_rate_store #(
  parameter int unsigned RATE_W   = dac_rate_pkg::RATE_W_DEF,
  parameter int unsigned FRAME_HZ = dac_rate_pkg::FRAME_HZ_DEF,
  parameter int unsigned MIN_HZ   = dac_rate_pkg::MIN_HZ_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [RATE_W-1:0] din,
  output logic [RATE_W-1:0] rate_q
);
  localparam logic [RATE_W-1:0] HI = RATE_W'(FRAME_HZ);
  localparam logic [RATE_W-1:0] LO = RATE_W'(MIN_HZ);

  // Saturate at write time so the accumulator never sees an illegal step.
  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= HI;
    end else if (wr) begin
      if (din < LO)      rate_q <= LO;
      else if (din > HI) rate_q <= HI;
      else               rate_q <= din;
    end
  end
endmodule

// File: rtl/dac_rate_accum.sv
module dac_rate_accum #(
  parameter int unsigned RATE_W   = dac_rate_pkg::RATE_W_DEF,
  parameter int unsigned FRAME_HZ = dac_rate_pkg::FRAME_HZ_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              restart,
  input  logic              var_en,
  input  logic [RATE_W-1:0] rate,
  output logic              want
);
  localparam int unsigned ACC_W = $clog2(2 * FRAME_HZ);
  localparam logic [ACC_W-1:0] LIM = ACC_W'(FRAME_HZ);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] base;
  logic [ACC_W-1:0] sum;

  // A restart in the same cycle as a tick counts that tick from zero.
  always_comb begin
    base = restart ? '0 : acc_q;
    sum  = base + ACC_W'(rate);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      want  <= 1'b1;
    end else if (tick) begin
      if (!var_en) begin
        acc_q <= '0;
        want  <= 1'b1;
      end else if (sum >= LIM) begin
        acc_q <= sum - LIM;
        want  <= 1'b1;
      end else begin
        acc_q <= sum;
        want  <= 1'b0;
      end
    end else if (restart) begin
      acc_q <= '0;
    end
  end
endmodule

// File: rtl/dac_sample_gate.sv
module dac_sample_gate #(
  parameter int unsigned SMP_W = dac_rate_pkg::SMP_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             want_cur,
  input  logic             in_valid,
  input  logic [SMP_W-1:0] in_l,
  input  logic [SMP_W-1:0] in_r,
  output logic             out_valid,
  output logic [SMP_W-1:0] out_l,
  output logic [SMP_W-1:0] out_r
);
  logic armed_q;
  logic take;

  assign take = in_valid & armed_q;

  // At a tick, want_cur still holds the decision of the frame now ending.
  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q   <= 1'b0;
      out_valid <= 1'b0;
      out_l     <= '0;
      out_r     <= '0;
    end else begin
      out_valid <= take;
      if (take) begin
        out_l <= in_l;
        out_r <= in_r;
      end
      if (tick)      armed_q <= want_cur;
      else if (take) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dac_rate_requester.sv
module dac_rate_requester #(
  parameter int unsigned RATE_W   = dac_rate_pkg::RATE_W_DEF,
  parameter int unsigned SMP_W    = dac_rate_pkg::SMP_W_DEF,
  parameter int unsigned FRAME_HZ = dac_rate_pkg::FRAME_HZ_DEF,
  parameter int unsigned MIN_HZ   = dac_rate_pkg::MIN_HZ_DEF,
  parameter int unsigned REQ_BITS = dac_rate_pkg::REQ_BITS_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frame_tick,
  input  logic                var_rate_en,
  input  logic                rate_wr,
  input  logic [RATE_W-1:0]   rate_val,
  input  logic                pcm_valid,
  input  logic [SMP_W-1:0]    pcm_left,
  input  logic [SMP_W-1:0]    pcm_right,
  output logic [REQ_BITS-1:0] req_n,
  output logic                smp_valid,
  output logic [SMP_W-1:0]    smp_left,
  output logic [SMP_W-1:0]    smp_right
);
  logic [RATE_W-1:0] rate_q;
  logic              en_q;
  logic              restart;
  logic              want;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= var_rate_en;
  end

  assign restart = rate_wr | (var_rate_en ^ en_q);

  dac_rate_store #(.RATE_W(RATE_W), .FRAME_HZ(FRAME_HZ), .MIN_HZ(MIN_HZ)) u_store (
    .clk(clk), .rst(rst), .wr(rate_wr), .din(rate_val), .rate_q(rate_q)
  );

  dac_rate_accum #(.RATE_W(RATE_W), .FRAME_HZ(FRAME_HZ)) u_accum (
    .clk(clk), .rst(rst), .tick(frame_tick), .restart(restart),
    .var_en(var_rate_en), .rate(rate_q), .want(want)
  );

  dac_sample_gate #(.SMP_W(SMP_W)) u_gate (
    .clk(clk), .rst(rst), .tick(frame_tick), .want_cur(want),
    .in_valid(pcm_valid), .in_l(pcm_left), .in_r(pcm_right),
    .out_valid(smp_valid), .out_l(smp_left), .out_r(smp_right)
  );

  // All channels share one rate, so every request bit mirrors one decision.
  for (genvar g = 0; g < REQ_BITS; g++) begin : g_req
    assign req_n[g] = ~want;
  end
endmodule

// File: rtl/dac_rate_checker.sv
module dac_rate_checker #(
  parameter int unsigned RATE_W   = 16,
  parameter int unsigned SMP_W    = 20,
  parameter int unsigned FRAME_HZ = 48000,
  parameter int unsigned MIN_HZ   = 4000,
  parameter int unsigned REQ_BITS = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                frame_tick,
  input logic                var_rate_en,
  input logic                rate_wr,
  input logic                pcm_valid,
  input logic [REQ_BITS-1:0] req_n,
  input logic                smp_valid,
  input logic [SMP_W-1:0]    smp_left,
  input logic [SMP_W-1:0]    smp_right
);
  localparam int unsigned MAX_GAP = (FRAME_HZ + MIN_HZ - 1) / MIN_HZ;
  localparam int unsigned GAP_W   = $clog2(MAX_GAP + 2);

  logic             tick_q;
  logic             en_seen;
  logic [GAP_W-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q  <= 1'b0;
      en_seen <= 1'b0;
      gap_cnt <= '0;
    end else begin
      tick_q  <= frame_tick;
      en_seen <= var_rate_en;
      if (rate_wr || (var_rate_en != en_seen)) gap_cnt <= '0;
      else if (tick_q) begin
        if (req_n == '0) gap_cnt <= '0;
        else             gap_cnt <= gap_cnt + 1'b1;
      end
    end
  end

  a_r7_bits_match: assert property (@(posedge clk) disable iff (rst)
    (req_n == '0) || (req_n == '1));

  a_r11_req_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
    !frame_tick |=> $stable(req_n));

  a_r2_fixed_rate_every_frame: assert property (@(posedge clk) disable iff (rst)
    (frame_tick && !var_rate_en) |=> (req_n == '0));

  a_r8_accept_follows_input: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> $past(pcm_valid));

  a_r9_hold_data: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |-> ($stable(smp_left) && $stable(smp_right)));

  a_r3_gap_bound: assert property (@(posedge clk) disable iff (rst)
    gap_cnt < GAP_W'(MAX_GAP));
endmodule

bind dac_rate_requester dac_rate_checker #(
  .RATE_W(RATE_W), .SMP_W(SMP_W), .FRAME_HZ(FRAME_HZ),
  .MIN_HZ(MIN_HZ), .REQ_BITS(REQ_BITS)
) u_chk (
  .clk(clk), .rst(rst), .frame_tick(frame_tick), .var_rate_en(var_rate_en),
  .rate_wr(rate_wr), .pcm_valid(pcm_valid), .req_n(req_n),
  .smp_valid(smp_valid), .smp_left(smp_left), .smp_right(smp_right)
);

// File: tb/test_dac_rate_requester.sv
`timescale 1ns/1ps
module test_dac_rate_requester;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_tick = 1'b0;
  logic        var_rate_en = 1'b0;
  logic        rate_wr = 1'b0;
  logic [15:0] rate_val = '0;
  logic        pcm_valid = 1'b0;
  logic [19:0] pcm_left = '0;
  logic [19:0] pcm_right = '0;
  logic [1:0]  req_n;
  logic        smp_valid;
  logic [19:0] smp_left;
  logic [19:0] smp_right;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  dac_rate_requester i_dac_rate_requester (
    .clk(clk), .rst(rst), .frame_tick(frame_tick), .var_rate_en(var_rate_en),
    .rate_wr(rate_wr), .rate_val(rate_val), .pcm_valid(pcm_valid),
    .pcm_left(pcm_left), .pcm_right(pcm_right), .req_n(req_n),
    .smp_valid(smp_valid), .smp_left(smp_left), .smp_right(smp_right)
  );

  typedef struct packed {
    logic        en;
    logic [15:0] rate;
    logic [7:0]  frames;
    logic [7:0]  reqs;
    logic [7:0]  first;
    logic [7:0]  gmin;
    logic [7:0]  gmax;
  } vec_t;

  // en, rate, frames, expected requests, first request frame, min gap, max gap
  localparam vec_t VECS [8] = '{
    '{1'b0, 16'd8000,  8'd12, 8'd12, 8'd1,  8'd1,  8'd1},   // R2
    '{1'b1, 16'd8000,  8'd24, 8'd4,  8'd6,  8'd6,  8'd6},   // R4
    '{1'b1, 16'd9600,  8'd20, 8'd4,  8'd5,  8'd5,  8'd5},   // R4
    '{1'b1, 16'd12000, 8'd16, 8'd4,  8'd4,  8'd4,  8'd4},   // R4
    '{1'b1, 16'd48000, 8'd10, 8'd10, 8'd1,  8'd1,  8'd1},   // R3
    '{1'b1, 16'd1000,  8'd24, 8'd2,  8'd12, 8'd12, 8'd12},  // R6 low clamp
    '{1'b1, 16'd60000, 8'd10, 8'd10, 8'd1,  8'd1,  8'd1},   // R6 high clamp
    '{1'b1, 16'd8800,  8'd60, 8'd11, 8'd6,  8'd5,  8'd6}    // R5
  };

  task automatic chk(input string tag, input logic ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(output logic [1:0] pre, output logic [1:0] post);
    @(negedge clk);
    frame_tick = 1'b1;
    pre = req_n;
    @(negedge clk);
    frame_tick = 1'b0;
    post = req_n;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_rate(input logic [15:0] r);
    @(negedge clk);
    rate_wr = 1'b1;
    rate_val = r;
    @(negedge clk);
    rate_wr = 1'b0;
    idle(1);
  endtask

  task automatic send(input logic [19:0] l, input logic [19:0] r);
    @(negedge clk);
    pcm_valid = 1'b1;
    pcm_left = l;
    pcm_right = r;
    @(negedge clk);
    pcm_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [1:0]  pre;
    logic [1:0]  post;
    vec_t        cv;
    int          cnt;
    int          first;
    int          last;
    logic        prev;
    logic [19:0] last_l;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 req_n after reset", req_n == 2'b00, req_n, 0);
    chk("R1 smp_valid after reset", smp_valid == 1'b0, smp_valid, 0);
    chk("R1 smp_left after reset", smp_left == '0, smp_left, 0);
    // R1: stored rate resets to 48000 -> every frame requests once enabled
    var_rate_en = 1'b1;
    idle(2);
    for (int f = 0; f < 3; f++) begin
      tick(pre, post);
      chk("R1 default rate requests every frame", post == 2'b00, post, 0);
      idle(2);
    end

    // Table of rate cases
    for (int v = 0; v < 8; v++) begin
      cv = VECS[v];
      var_rate_en = cv.en;
      idle(2);
      write_rate(cv.rate);
      cnt = 0;
      first = 0;
      last = 0;
      for (int f = 1; f <= int'(cv.frames); f++) begin
        tick(pre, post);
        // R7: both bits are the same
        if (post != 2'b00 && post != 2'b11)
          chk("R7 request bits differ", 1'b0, post, 0);
        if (post == 2'b00) begin
          cnt++;
          if (first == 0) first = f;
          else chk("R3/R4/R5 request gap", (f - last) >= int'(cv.gmin) && (f - last) <= int'(cv.gmax),
                   f - last, int'(cv.gmin));
          last = f;
        end
        idle(2);
      end
      chk("R3 request count", cnt == int'(cv.reqs), cnt, int'(cv.reqs));
      chk("R4 first request frame", first == int'(cv.first), first, int'(cv.first));
    end

    // R8 / R9: acceptance only after a requesting frame, once per frame
    var_rate_en = 1'b1;
    write_rate(16'd8000);
    prev = (req_n == 2'b00);
    last_l = smp_left;
    for (int f = 1; f <= 14; f++) begin
      tick(pre, post);
      idle(1);
      send(20'(f * 3 + 1), 20'(f) ^ 20'hABCDE);
      chk("R8 accept only after request", smp_valid == prev, smp_valid, prev);
      if (prev) begin
        last_l = 20'(f * 3 + 1);
        chk("R11 accepted left data", smp_left == last_l, smp_left, last_l);
        chk("R11 accepted right data", smp_right == (20'(f) ^ 20'hABCDE), smp_right, 20'(f) ^ 20'hABCDE);
      end
      send(20'hFFFFF, 20'h12345);
      chk("R9 second pair in frame dropped", smp_valid == 1'b0, smp_valid, 0);
      idle(1);
      chk("R9 data held", smp_left == last_l, smp_left, last_l);
      prev = (post == 2'b00);
    end

    // R10: enable toggle clears the accumulator
    write_rate(16'd8000);
    for (int f = 0; f < 3; f++) begin tick(pre, post); idle(2); end
    var_rate_en = 1'b0;
    idle(2);
    var_rate_en = 1'b1;
    idle(2);
    for (int f = 1; f <= 6; f++) begin
      tick(pre, post);
      if (f < 6) chk("R10 no request before sixth frame after toggle", post == 2'b11, post, 3);
      else begin
        chk("R11 req_n unchanged during tick cycle", pre == 2'b11, pre, 3);
        chk("R10 request in sixth frame after toggle", post == 2'b00, post, 0);
      end
      idle(2);
    end

    // R10: rate rewrite clears the accumulator
    for (int f = 0; f < 3; f++) begin tick(pre, post); idle(2); end
    write_rate(16'd8000);
    for (int f = 1; f <= 6; f++) begin
      tick(pre, post);
      if (f < 6) chk("R10 no request before sixth frame after rewrite", post == 2'b11, post, 3);
      else       chk("R10 request in sixth frame after rewrite", post == 2'b00, post, 0);
      idle(2);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule